// File: doc/BRIEF.md
# Interrupting Parallel I/O Slave

This block sits on a 16-bit processor bus as a slave and connects it to an external alarm and communications controller through two 12-bit parallel paths. Software reaches three registers, each at its own address. The status register reports whether a word from the external side is waiting. The control register holds a software word whose bit 0 allows an interrupt. The data register carries words in both directions. Each accepted access is answered with an active-low done signal, which frees the bus.

Inbound words use a valid/ready handshake. The external side raises `ext_in_valid` with a word and holds both until it sees `ext_in_ready` high at a rising clock edge. Ready is low while a word is pending, so the pending word is never overwritten. Ready is also low during the single cycle in which a clearing write to the status register is accepted. Software takes the word by reading the data register. It learns that a word is waiting either from the level-1 interrupt or by polling the status register.

Outbound words are written into the data register. They appear on `ext_out_word` together with a single-cycle strobe. Any write to the status register, whatever its data, clears the interface.

Top module: `pio_slave`

## Requirements
- R1: Only addresses 0xF920 (status), 0xF926 (control) and 0xF928 (data) are decoded. A bus cycle at any other address gets no done response and changes no register.
- R2: `bus_wr_n` low at acceptance writes the addressed register. High reads it, and the read value is held on `bus_rdata` while `bus_done_n` is low.
- R3: An access is accepted at the first rising edge where `bus_cyc` is high on a decoded address. `bus_done_n` goes low after that edge and stays low until the edge after `bus_cyc` falls. Each bus cycle performs exactly one access.
- R4: A write to the status address clears the control register, the pending flag and the outbound word to zero, whatever `bus_wdata` holds.
- R5: Reading status returns the pending flag in bit 0 and zeros in bits 15..1.
- R6: The control register stores and returns all 16 written bits. Bit 0 is the interrupt enable.
- R7: `irq_l1` is high exactly when the pending flag and control bit 0 are both set.
- R8: `ext_in_ready` is high only while no word is pending and no status write is being accepted. A handshake stores the word and sets the pending flag at that edge.
- R9: Reading the data register returns the stored inbound word zero-extended to 16 bits and clears the pending flag.
- R10: Writing the data register puts bits 11..0 on `ext_out_word` and raises `ext_out_stb` for exactly one cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus master cycle request, held until done |
| bus_addr | input | 16 | Register address |
| bus_wr_n | input | 1 | Low = write, high = read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while done is low |
| bus_done_n | output | 1 | Active-low access complete |
| irq_l1 | output | 1 | Level-1 interrupt request |
| ext_in_valid | input | 1 | Inbound word offered |
| ext_in_word | input | 12 | Inbound word |
| ext_in_ready | output | 1 | Inbound word can be taken |
| ext_out_word | output | 12 | Outbound word |
| ext_out_stb | output | 1 | One-cycle strobe for a new outbound word |

## Verification
The hardest cases are an inbound word arriving in the same cycle that a clearing status write is accepted, and a new word offered back-to-back behind a data read that frees the pending slot. The bench reaches the first case by raising `ext_in_valid` at the same moment it starts the status write. That forces the handshake to wait one edge and then land after the clear. It reaches the second case by leaving a second word offered while the first is still pending, so it enters on the edge right after the read. A per-cycle reference model tracks both cases.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BUS_W = 16;
  localparam int EXT_W = 12;
  localparam logic [BUS_W-1:0] ADR_STATUS  = 16'hF920;
  localparam logic [BUS_W-1:0] ADR_CONTROL = 16'hF926;
  localparam logic [BUS_W-1:0] ADR_DATA    = 16'hF928;
  localparam int PEND_BIT = 0;
  localparam int IEN_BIT  = 0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_DATA = 2'd3
  } pio_sel_e;

  typedef struct packed {
    logic     fire;
    logic     wr;
    pio_sel_e sel;
  } pio_acc_t;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int AW = BUS_W
) (
  input  logic          cyc,
  input  logic [AW-1:0] addr,
  input  logic          wr_n,
  input  logic          busy,
  output pio_acc_t      acc
);
  localparam int NREG = 3;
  localparam logic [AW-1:0] MAP [NREG] = '{ADR_STATUS, ADR_CONTROL, ADR_DATA};
  localparam pio_sel_e SELS [NREG] = '{SEL_STAT, SEL_CTRL, SEL_DATA};

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_match
    assign hit[g] = (addr == MAP[g]);
  end

  always_comb begin
    acc.sel = SEL_NONE;
    for (int k = 0; k < NREG; k++) begin
      if (hit[k]) acc.sel = SELS[k];
    end
    acc.fire = cyc && !busy && (acc.sel != SEL_NONE);
    acc.wr   = !wr_n;
  end
endmodule

// File: rtl/pio_bus_hs.sv
module pio_bus_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc,
  input  logic fire,
  output logic busy,
  output logic done_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy <= 1'b0;
    else if (fire) busy <= 1'b1;
    else if (!cyc) busy <= 1'b0;
  end

  assign done_n = !busy;
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int DW = BUS_W,
  parameter int XW = EXT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pio_acc_t      acc,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          in_valid,
  input  logic [XW-1:0] in_word,
  output logic          in_ready,
  output logic [XW-1:0] out_word,
  output logic          out_stb,
  output logic          pend,
  output logic          ien
);
  localparam int PADW = DW - XW;

  logic [DW-1:0] ctrl_q;
  logic [XW-1:0] in_q;
  logic [XW-1:0] out_q;
  logic          pend_q;
  logic          stb_q;
  logic [DW-1:0] rd_q;

  logic wr_stat, wr_ctrl, wr_data, rd_any, rd_data, take;

  assign wr_stat  = acc.fire &&  acc.wr && (acc.sel == SEL_STAT);
  assign wr_ctrl  = acc.fire &&  acc.wr && (acc.sel == SEL_CTRL);
  assign wr_data  = acc.fire &&  acc.wr && (acc.sel == SEL_DATA);
  assign rd_any   = acc.fire && !acc.wr;
  assign rd_data  = rd_any && (acc.sel == SEL_DATA);
  assign in_ready = !pend_q && !wr_stat;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      out_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (wr_stat) begin
        ctrl_q <= '0;
        out_q  <= '0;
      end
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_data) begin
        out_q <= wdata[XW-1:0];
        stb_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      in_q   <= '0;
    end else begin
      if (take) begin
        pend_q <= 1'b1;
        in_q   <= in_word;
      end else if (wr_stat || rd_data) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_any) begin
      unique case (acc.sel)
        SEL_STAT: begin
          rd_q <= '0;
          rd_q[PEND_BIT] <= pend_q;
        end
        SEL_CTRL: rd_q <= ctrl_q;
        SEL_DATA: rd_q <= {{PADW{1'b0}}, in_q};
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rdata    = rd_q;
  assign out_word = out_q;
  assign out_stb  = stb_q;
  assign pend     = pend_q;
  assign ien      = ctrl_q[IEN_BIT];
endmodule

// File: rtl/pio_slave.sv
module pio_slave
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cyc,
  input  logic [BUS_W-1:0] bus_addr,
  input  logic             bus_wr_n,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_done_n,
  output logic             irq_l1,
  input  logic             ext_in_valid,
  input  logic [EXT_W-1:0] ext_in_word,
  output logic             ext_in_ready,
  output logic [EXT_W-1:0] ext_out_word,
  output logic             ext_out_stb
);
  pio_acc_t acc;
  logic     busy;
  logic     pend;
  logic     ien;

  pio_decode #(.AW(BUS_W)) u_dec (
    .cyc  (bus_cyc),
    .addr (bus_addr),
    .wr_n (bus_wr_n),
    .busy (busy),
    .acc  (acc)
  );

  pio_bus_hs u_hs (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc    (bus_cyc),
    .fire   (acc.fire),
    .busy   (busy),
    .done_n (bus_done_n)
  );

  pio_regs #(.DW(BUS_W), .XW(EXT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .in_valid (ext_in_valid),
    .in_word  (ext_in_word),
    .in_ready (ext_in_ready),
    .out_word (ext_out_word),
    .out_stb  (ext_out_stb),
    .pend     (pend),
    .ien      (ien)
  );

  assign irq_l1 = pend && ien;
endmodule

// File: rtl/pio_slave_chk.sv
module pio_slave_chk
  import pio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_cyc,
  input logic             bus_done_n,
  input logic             irq_l1,
  input logic             ext_in_valid,
  input logic             ext_in_ready,
  input logic [EXT_W-1:0] ext_out_word,
  input logic             ext_out_stb,
  input logic             fire,
  input logic             wr,
  input logic [1:0]       sel,
  input logic             pend,
  input logic             ien
);
  logic take;
  assign take = ext_in_valid && ext_in_ready;

  p_done_needs_cyc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_done_n |-> $past(bus_cyc));

  p_done_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_done_n && !bus_cyc) |=> bus_done_n);

  p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr && sel == 2'd1) |=> (!pend && !ien && ext_out_word == '0));

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_l1) |-> ($past(take) || $past(fire && wr && sel == 2'd2)));

  p_ready_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !ext_in_ready);

  p_take_sets_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pend);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr && sel == 2'd3 && !take) |=> !pend);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_out_stb |=> !ext_out_stb);
endmodule

bind pio_slave pio_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_cyc      (bus_cyc),
  .bus_done_n   (bus_done_n),
  .irq_l1       (irq_l1),
  .ext_in_valid (ext_in_valid),
  .ext_in_ready (ext_in_ready),
  .ext_out_word (ext_out_word),
  .ext_out_stb  (ext_out_stb),
  .fire         (acc.fire),
  .wr           (acc.wr),
  .sel          (acc.sel),
  .pend         (pend),
  .ien          (ien)
);

// File: tb/sim_pio_slave.sv
`timescale 1ns/1ps
module sim_pio_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cyc = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr_n = 1'b1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_done_n;
  logic        irq_l1;
  logic        ext_in_valid = 1'b0;
  logic [11:0] ext_in_word = '0;
  logic        ext_in_ready;
  logic [11:0] ext_out_word;
  logic        ext_out_stb;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pio_slave u0 (.*);

  // reference model state
  bit        m_busy, m_pend, m_stb;
  int        m_ctrl, m_in, m_out, m_rd;

  function automatic bit is_reg(input logic [15:0] a);
    return a == 16'hF920 || a == 16'hF926 || a == 16'hF928;
  endfunction

  function automatic bit m_ready();
    return !m_pend && !(bus_cyc && !m_busy && bus_addr == 16'hF920 && !bus_wr_n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_stb = 0;
      m_ctrl = 0; m_in = 0; m_out = 0; m_rd = 0;
    end else begin
      bit acc, hs;
      acc = bus_cyc && !m_busy && is_reg(bus_addr);
      hs  = ext_in_valid && m_ready();
      m_stb = 0;
      if (!bus_cyc) m_busy = 0;
      if (acc) begin
        m_busy = 1;
        if (!bus_wr_n) begin
          if (bus_addr == 16'hF920) begin m_ctrl = 0; m_pend = 0; m_out = 0; end
          else if (bus_addr == 16'hF926) m_ctrl = bus_wdata;
          else begin m_out = bus_wdata & 16'h0FFF; m_stb = 1; end
        end else begin
          if (bus_addr == 16'hF920) m_rd = m_pend;
          else if (bus_addr == 16'hF926) m_rd = m_ctrl;
          else begin m_rd = m_in; m_pend = 0; end
        end
      end
      if (hs) begin m_in = ext_in_word; m_pend = 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(bus_done_n == !m_busy, "R3 done", bus_done_n, !m_busy);
      if (!bus_done_n) chk(bus_rdata == m_rd[15:0], "R2 rdata", bus_rdata, m_rd);
      chk(ext_out_stb == m_stb, "R10 strobe", ext_out_stb, m_stb);
      chk(ext_out_word == m_out[11:0], "R10 out word", ext_out_word, m_out);
      chk(irq_l1 == (m_pend && m_ctrl[0]), "R7 irq", irq_l1, m_pend && m_ctrl[0]);
      chk(ext_in_ready == m_ready(), "R8 ready", ext_in_ready, m_ready());
    end
  end

  task automatic bus_op(input logic [15:0] a, input bit wr, input logic [15:0] wd,
                        input bit with_in, output logic [15:0] rd, output bit got);
    @(negedge clk); #2;
    bus_cyc = 1; bus_addr = a; bus_wr_n = !wr; bus_wdata = wd;
    if (with_in) ext_in_valid = 1;
    got = 0; rd = '0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!bus_done_n) begin got = 1; rd = bus_rdata; break; end
    end
    #2 bus_cyc = 0; bus_wr_n = 1;
    @(negedge clk);
  endtask

  logic [15:0] rv;
  bit          g;

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    @(negedge clk); #1;
    // reset state
    chk(bus_done_n == 1, "R3 reset done", bus_done_n, 1);
    chk(irq_l1 == 0, "R7 reset irq", irq_l1, 0);
    chk(ext_in_ready == 1, "R8 reset ready", ext_in_ready, 1);
    chk(ext_out_word == 0 && ext_out_stb == 0, "R10 reset out", ext_out_word, 0);

    bus_op(16'hF920, 0, 0, 0, rv, g);
    chk(g && rv == 0, "R5 status idle", rv, 0);
    bus_op(16'hF926, 1, 16'hA5A4, 0, rv, g);
    bus_op(16'hF926, 0, 0, 0, rv, g);
    chk(rv == 16'hA5A4, "R6 control readback", rv, 16'hA5A4);

    // inbound word, polling mode
    @(negedge clk); #2 ext_in_valid = 1; ext_in_word = 12'h123;
    @(negedge clk); #2 ext_in_word = 12'h456;
    repeat (3) @(negedge clk);
    chk(ext_in_ready == 0, "R8 blocked while pending", ext_in_ready, 0);
    chk(irq_l1 == 0, "R7 no irq when disabled", irq_l1, 0);
    bus_op(16'hF920, 0, 0, 0, rv, g);
    chk(rv == 16'h0001, "R5 pending bit", rv, 1);

    bus_op(16'hF926, 1, 16'h0001, 0, rv, g);
    chk(irq_l1 == 1, "R7 irq enabled", irq_l1, 1);
    bus_op(16'hF928, 0, 0, 0, rv, g);
    chk(rv == 16'h0123, "R9 data read", rv, 16'h0123);
    #2 ext_in_valid = 0;
    bus_op(16'hF920, 0, 0, 0, rv, g);
    chk(rv == 16'h0001, "R8 back-to-back word taken", rv, 1);
    bus_op(16'hF928, 0, 0, 0, rv, g);
    chk(rv == 16'h0456, "R9 second word zero-extended", rv, 16'h0456);
    chk(irq_l1 == 0, "R9 pending cleared", irq_l1, 0);

    // outbound
    bus_op(16'hF928, 1, 16'hFABC, 0, rv, g);
    chk(ext_out_word == 12'hABC, "R10 out word latched", ext_out_word, 12'hABC);

    // unmapped addresses
    bus_op(16'hF922, 1, 16'hFFFF, 0, rv, g);
    chk(!g, "R1 no done F922", g, 0);
    bus_op(16'hF92A, 1, 16'h0000, 0, rv, g);
    chk(!g, "R1 no done F92A", g, 0);
    bus_op(16'hF926, 0, 0, 0, rv, g);
    chk(rv == 16'h0001, "R1 control untouched", rv, 1);

    // clear with a word offered in the same cycle
    ext_in_word = 12'h777;
    bus_op(16'hF920, 1, 16'hFFFF, 1, rv, g);
    chk(g, "R2 write done", g, 1);
    chk(ext_out_word == 0, "R4 out word cleared", ext_out_word, 0);
    #2 ext_in_valid = 0;
    bus_op(16'hF926, 0, 0, 0, rv, g);
    chk(rv == 0, "R4 control cleared", rv, 0);
    bus_op(16'hF920, 0, 0, 0, rv, g);
    chk(rv == 16'h0001, "R8 word after clear", rv, 1);
    bus_op(16'hF928, 0, 0, 0, rv, g);
    chk(rv == 16'h0777, "R8 word value after clear", rv, 16'h0777);

    // clear drops a pending interrupt
    bus_op(16'hF926, 1, 16'h8001, 0, rv, g);
    @(negedge clk); #2 ext_in_valid = 1; ext_in_word = 12'h0AA;
    @(negedge clk); #2 ext_in_valid = 0;
    @(negedge clk);
    chk(irq_l1 == 1, "R7 irq raised", irq_l1, 1);
    bus_op(16'hF920, 1, 16'h0000, 0, rv, g);
    chk(irq_l1 == 0, "R4 clear drops irq", irq_l1, 0);
    bus_op(16'hF920, 0, 0, 0, rv, g);
    chk(rv == 0, "R4 pending cleared", rv, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule